// File: doc/BRIEF.md
# PASID Command/Response Allocator

This unit gives software a mailbox for obtaining and returning process address space identifiers. Software posts a command with one 32-bit write and then polls a response word. The response word packs a busy flag, a two-bit outcome code and the granted identifier. Behind the mailbox sits a bitmap pool of `POOL_N` identifiers numbered 1 to `POOL_N`. Identifier 0 is never handed out.

An allocation walks the bitmap upward one entry per clock and takes the first clear entry. A release checks the identifier against the pool and clears its bit. A capability word tells software whether the mailbox is active. When the `CAP_EN` parameter is clear, the mailbox ignores every command. While one command is still running, the unit drops any further command write without trace.

Top module: `vcp_unit`

## Requirements
- R1: After reset the pool is empty and the response word reads 0.
- R2: Register map on a 32-bit bus. Each register is 64 bits wide, with its upper half at +4.
  - 0xE00 is the capability word. Bit 0 equals `CAP_EN` and all other bits read 0.
  - 0xE10 is the command word. Reads return 0, and only a write to the lower half posts a command.
  - 0xE20 is the response word. Its upper half reads 0.
  - Any read with the read strobe low returns 0.
- R3: Command word layout: bits [7:0] hold the opcode (0 null, 1 allocate, 2 release) and bits [27:8] hold a 20-bit identifier. Response word layout: bit 0 is busy, bits [2:1] are the status and bits [27:8] are the result. Any opcode other than 0, 1 or 2 finishes with status 1 and result 0. Status 3 never appears.
- R4: A null command finishes on the clock after it is accepted, with status 0 and result 0.
- R5: Allocation returns the lowest free identifier with status 0 and marks it used. Busy stays set while the bitmap is scanned one entry per clock, so the command finishes no more than `POOL_N` clocks after acceptance.
- R6: Allocation from a full pool finishes with status 2 and result 0.
- R7: Release of an identifier that is in range and in use finishes with status 0 and makes that identifier free again.
- R8: Release of identifier 0, of an identifier above `POOL_N`, or of an identifier not in use finishes with status 2 and leaves the pool unchanged.
- R9: A command write that arrives while busy is set has no effect on the running command or on the pool.
- R10: With `CAP_EN` clear, command writes are ignored and the response word stays 0.
- R11: Accepting a command clears the previous status and result fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |

## Verification
The bench builds two copies of the block, both with `POOL_N` set to 8.
- The first has the capability enabled. The small pool lets a short run fill every entry, which reaches the exhausted-pool status and the full-length scan. It also puts identifiers just past the top of the pool (9) within easy reach for the out-of-range release case.
- The second copy has `CAP_EN` cleared, so ignored commands are observed on a separate instance without disturbing the first.

Freeing an identifier and allocating again shows that the lowest-free search reuses holes.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    localparam int PASID_W = 20;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 12'hE00;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 12'hE04;
    localparam logic [ADDR_W-1:0] OFS_CMD_LO = 12'hE10;
    localparam logic [ADDR_W-1:0] OFS_CMD_HI = 12'hE14;
    localparam logic [ADDR_W-1:0] OFS_RSP_LO = 12'hE20;
    localparam logic [ADDR_W-1:0] OFS_RSP_HI = 12'hE24;

    localparam logic [7:0] OPC_NULL  = 8'd0;
    localparam logic [7:0] OPC_ALLOC = 8'd1;
    localparam logic [7:0] OPC_FREE  = 8'd2;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_UNDEF  = 2'd1,
        ST_NOPASID = 2'd2
    } vc_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_SINGLE
    } vc_state_e;

    typedef struct packed {
        logic [PASID_W-1:0] pasid;
        logic [7:0]         op;
    } vc_cmd_t;

    typedef struct packed {
        logic [PASID_W-1:0] result;
        vc_status_e         status;
        logic               busy;
    } vc_rsp_t;

    function automatic vc_cmd_t cmd_decode(input logic [31:0] w);
        vc_cmd_t c;
        c.op    = w[7:0];
        c.pasid = w[27:8];
        return c;
    endfunction

    function automatic logic [31:0] rsp_word(input vc_rsp_t r);
        return {4'b0, r.result, 5'b0, r.status, r.busy};
    endfunction

endpackage

// File: rtl/vcp_pool.sv
module vcp_pool #(
    parameter int POOL_N = 64,
    localparam int IDX_W = (POOL_N > 1) ? $clog2(POOL_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_used,
    input  logic             set_en,
    input  logic             clr_en,
    output logic [POOL_N-1:0] map
);

    for (genvar i = 0; i < POOL_N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                map[i] <= 1'b0;
            end else if (set_en && look_idx == IDX_W'(i)) begin
                map[i] <= 1'b1;
            end else if (clr_en && look_idx == IDX_W'(i)) begin
                map[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        look_used = 1'b0;
        for (int j = 0; j < POOL_N; j++) begin
            if (look_idx == IDX_W'(j)) look_used = map[j];
        end
    end

endmodule

// File: rtl/vcp_ctrl.sv
module vcp_ctrl
    import vcp_pkg::*;
#(
    parameter int POOL_N = 64,
    parameter bit CAP_EN = 1'b1,
    localparam int IDX_W = (POOL_N > 1) ? $clog2(POOL_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_post,
    input  vc_cmd_t          cmd_in,
    output vc_rsp_t          rsp,
    output logic [IDX_W-1:0] look_idx,
    input  logic             look_used,
    output logic             set_en,
    output logic             clr_en
);

    vc_state_e          state;
    vc_cmd_t            cmd_q;
    logic [IDX_W-1:0]   scan_idx;
    logic               in_range;
    logic               accept;
    logic [PASID_W-1:0] pasid_m1;

    assign accept   = cmd_post && CAP_EN && !rsp.busy;
    assign in_range = (cmd_q.pasid != '0) && (cmd_q.pasid <= PASID_W'(POOL_N));
    assign pasid_m1 = cmd_q.pasid - PASID_W'(1);

    always_comb begin
        look_idx = (state == S_SCAN) ? scan_idx : pasid_m1[IDX_W-1:0];
        set_en   = (state == S_SCAN) && !look_used;
        clr_en   = (state == S_SINGLE) && (cmd_q.op == OPC_FREE) && in_range && look_used;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            rsp      <= '0;
            cmd_q    <= '0;
            scan_idx <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        rsp.busy   <= 1'b1;
                        rsp.status <= ST_OK;
                        rsp.result <= '0;
                        cmd_q      <= cmd_in;
                        scan_idx   <= '0;
                        state      <= (cmd_in.op == OPC_ALLOC) ? S_SCAN : S_SINGLE;
                    end
                end
                S_SCAN: begin
                    if (!look_used) begin
                        rsp.result <= PASID_W'(scan_idx) + PASID_W'(1);
                        rsp.busy   <= 1'b0;
                        state      <= S_IDLE;
                    end else if (scan_idx == IDX_W'(POOL_N - 1)) begin
                        rsp.status <= ST_NOPASID;
                        rsp.busy   <= 1'b0;
                        state      <= S_IDLE;
                    end else begin
                        scan_idx <= scan_idx + IDX_W'(1);
                    end
                end
                S_SINGLE: begin
                    case (cmd_q.op)
                        OPC_NULL: rsp.status <= ST_OK;
                        OPC_FREE: rsp.status <= clr_en ? ST_OK : ST_NOPASID;
                        default:  rsp.status <= ST_UNDEF;
                    endcase
                    rsp.busy <= 1'b0;
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vcp_regbus.sv
module vcp_regbus
    import vcp_pkg::*;
#(
    parameter bit CAP_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    input  logic [31:0]       rsp_lo,
    output logic              cmd_post,
    output vc_cmd_t           cmd,
    output logic [31:0]       bus_rdata
);

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[31:28];

    assign cmd_post = bus_wr && (bus_addr == OFS_CMD_LO);
    assign cmd      = cmd_decode(bus_wdata);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CAP_LO: bus_rdata = {31'b0, CAP_EN};
                OFS_RSP_LO: bus_rdata = rsp_lo;
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/vcp_unit.sv
module vcp_unit
    import vcp_pkg::*;
#(
    parameter int POOL_N = 64,
    parameter bit CAP_EN = 1'b1,
    localparam int IDX_W = (POOL_N > 1) ? $clog2(POOL_N) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata
);

    vc_cmd_t            cmd;
    logic               cmd_post;
    vc_rsp_t            rsp;
    logic [IDX_W-1:0]   look_idx;
    logic               look_used;
    logic               set_en;
    logic               clr_en;
    logic [POOL_N-1:0]  pool_map;
    logic               rsp_busy;
    logic [1:0]         rsp_status;
    logic [PASID_W-1:0] rsp_result;

    assign rsp_busy   = rsp.busy;
    assign rsp_status = rsp.status;
    assign rsp_result = rsp.result;

    vcp_regbus #(.CAP_EN(CAP_EN)) u_regbus (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .rsp_lo    (rsp_word(rsp)),
        .cmd_post  (cmd_post),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    vcp_ctrl #(.POOL_N(POOL_N), .CAP_EN(CAP_EN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_post  (cmd_post),
        .cmd_in    (cmd),
        .rsp       (rsp),
        .look_idx  (look_idx),
        .look_used (look_used),
        .set_en    (set_en),
        .clr_en    (clr_en)
    );

    vcp_pool #(.POOL_N(POOL_N)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (look_idx),
        .look_used (look_used),
        .set_en    (set_en),
        .clr_en    (clr_en),
        .map       (pool_map)
    );

endmodule

// File: rtl/vcp_unit_chk.sv
module vcp_unit_chk #(
    parameter int POOL_N = 64,
    parameter bit CAP_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic [1:0]        status,
    input logic [19:0]       result,
    input logic [POOL_N-1:0] pool
);

    logic [31:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_cnt <= '0;
        else              busy_cnt <= busy_cnt + 32'd1;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && status == 2'd0 && result == '0 && pool == '0)); // R1

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        status != 2'd3); // R3

    AST_SCAN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy_cnt <= 32'(POOL_N)); // R5

    AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!busy && result != '0) |-> (result <= 20'(POOL_N) && status == 2'd0)); // R5

    AST_POOL_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(pool ^ $past(pool)) <= 1); // R7

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (status == 2'd0 && result == '0)); // R11

    AST_NO_CAP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !CAP_EN |-> (!busy && pool == '0)); // R10

endmodule

bind vcp_unit vcp_unit_chk #(.POOL_N(POOL_N), .CAP_EN(CAP_EN)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (rsp_busy),
    .status (rsp_status),
    .result (rsp_result),
    .pool   (pool_map)
);

// File: tb/vcp_unit_tb_top.sv
module vcp_unit_tb_top;
    import vcp_pkg::*;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [11:0] wr_addr = '0, rd_addr = '0, bus_addr;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    assign bus_addr = wr_en ? wr_addr : rd_addr;

    logic [11:0] nc_addr = '0;
    logic        nc_wr = 1'b0, nc_rd = 1'b0;
    logic [31:0] nc_wdata = '0, nc_rdata;

    vcp_unit #(.POOL_N(N), .CAP_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(wr_en),
        .bus_wdata(wdata), .bus_rd(rd_en), .bus_rdata(rdata)
    );

    vcp_unit #(.POOL_N(N), .CAP_EN(1'b0)) dut_nc (
        .clk(clk), .rst(rst), .bus_addr(nc_addr), .bus_wr(nc_wr),
        .bus_wdata(nc_wdata), .bus_rd(nc_rd), .bus_rdata(nc_rdata)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] rsp_val(input int res, input int st);
        return (32'(res) << 8) | (32'(st) << 1);
    endfunction

    // Driver: post a command and push the expected response
    task automatic run_cmd(input string tag, input logic [31:0] cmd, input logic [31:0] exp);
        bus_write(OFS_CMD_LO, cmd);
        sb_q.push_back('{exp, tag});
        wait (sb_q.size() == 0);
    endtask

    // Monitor: poll until busy clears, then compare with the scoreboard head
    initial begin
        logic [31:0] r;
        forever begin
            wait (sb_q.size() > 0);
            for (int g = 0; g < 200; g++) begin
                bus_read(OFS_RSP_LO, r);
                if (!r[0]) break;
            end
            check(sb_q[0].tag, r, sb_q[0].exp);
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        bus_read(OFS_RSP_LO, r);  check("R1 response after reset", r, 32'h0);
        bus_read(OFS_CAP_LO, r);  check("R2 capability low", r, 32'h1);
        bus_read(OFS_CAP_HI, r);  check("R2 capability high", r, 32'h0);
        bus_read(OFS_CMD_LO, r);  check("R2 command reads zero", r, 32'h0);
        bus_read(OFS_RSP_HI, r);  check("R2 response high", r, 32'h0);

        run_cmd("R4 null command", 32'h0, rsp_val(0, 0));
        run_cmd("R5 first alloc",  32'h1, rsp_val(1, 0));
        run_cmd("R5 second alloc", 32'h1, rsp_val(2, 0));
        run_cmd("R5 third alloc",  32'h1, rsp_val(3, 0));
        run_cmd("R7 free 2",       32'h202, rsp_val(0, 0));
        run_cmd("R5 alloc reuses hole", 32'h1, rsp_val(2, 0));
        run_cmd("R8 free 0",            32'h002, rsp_val(0, 2));
        run_cmd("R8 free above pool",   32'h902, rsp_val(0, 2));
        run_cmd("R8 free unallocated",  32'h502, rsp_val(0, 2));
        run_cmd("R3 undefined opcode",  32'h37, rsp_val(0, 1));
        run_cmd("R11 null clears status", 32'h0, rsp_val(0, 0));
        run_cmd("R8 pool unchanged, alloc 4", 32'h1, rsp_val(4, 0));
        run_cmd("R5 alloc 5",           32'h1, rsp_val(5, 0));

        // R9: second write lands while the alloc scan is still busy
        bus_write(OFS_CMD_LO, 32'h1);
        bus_write(OFS_CMD_LO, 32'h102);
        sb_q.push_back('{rsp_val(6, 0), "R9 running alloc unaffected"});
        wait (sb_q.size() == 0);
        run_cmd("R9 discarded free left 1 in use", 32'h102, rsp_val(0, 0));
        run_cmd("R7 freed 1 allocatable", 32'h1, rsp_val(1, 0));
        run_cmd("R5 alloc 7",             32'h1, rsp_val(7, 0));
        run_cmd("R5 alloc 8",             32'h1, rsp_val(8, 0));
        run_cmd("R6 pool exhausted",      32'h1, rsp_val(0, 2));
        run_cmd("R11 null after failure", 32'h0, rsp_val(0, 0));

        // R10: capability clear
        @(negedge clk);
        nc_addr = OFS_CMD_LO; nc_wdata = 32'h1; nc_wr = 1'b1;
        @(negedge clk);
        nc_wr = 1'b0; nc_addr = OFS_RSP_LO; nc_rd = 1'b1;
        #1 check("R10 response stays zero", nc_rdata, 32'h0);
        repeat (3) @(negedge clk);
        #1 check("R10 response still zero", nc_rdata, 32'h0);
        nc_addr = OFS_CAP_LO;
        #1 check("R10 capability bit clear", nc_rdata, 32'h0);
        nc_rd = 1'b0;

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule